// File: doc/BRIEF.md
# Configuration Flash Reprogramming Sequencer

This block is a hardware sequencer that sits in front of a serial flash command engine and runs the whole command flow needed to rewrite or read back a configuration flash. A single start pulse, qualified by a mode input, launches either an update or a readback. The engine performs the serial shifting and holds the page buffers. The sequencer only decides which command runs next, with which clock count and which address, and when each one may start.

In an update, the sequencer first sets the write latch and erases the entire device. It then polls the status byte until the busy flag clears. After that it programs the image page by page. Each page gets its own write-latch command. Its payload is pulled from an input byte stream into the engine's transmit buffer, a program command follows, and status polling repeats before the next page. In a readback, the requested byte range is first clipped to the device capacity and then cut into bounded read commands. Each chunk is streamed out of the engine's receive buffer in order.

The engine interface carries one command at a time. The sequencer raises a one-cycle `cmd_go` with the opcode, clock count and address held stable. The engine answers with `eng_done` and a status byte.

Top module: `flash_reprog_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `busy`, `done`, `cmd_go`, `in_ready` and `out_valid` are all low.
- R2: An update with nonzero length first issues a write-latch command (opcode 0x60, 8 clocks), then a whole-device erase (opcode 0xE3, 8 clocks). It then issues status reads (opcode 0xA0, 16 clocks) repeatedly until a returned status byte has bit 7 clear. The other status bits are ignored.
- R3: The image is programmed in pages of 128 bytes. Each page is preceded by a write-latch command. Its bytes are then taken from the input stream with valid/ready handshakes and written to transmit-buffer slots 0, 1, 2, … in order. A program command follows (opcode 0x40, 32 + 8·n clocks for n bytes, address equal to the image offset of the page's first byte). Status is then polled as in R2 before the next page.
- R4: When the image length is not a multiple of 128, the final page carries only the remaining bytes, and its clock count and handshake count shrink to match.
- R5: A start with zero length, in either mode, issues no command and consumes no byte. `done` pulses in the cycle after start, while `busy` stays low.
- R6: A readback issues read commands (opcode 0xC0, 32 + 8·n clocks) of at most 247 bytes each. The address of each command advances by the size of the previous chunk, and the last chunk holds the remainder. After each command, the chunk's bytes are presented on the output stream in order. `rx_idx` selects receive-buffer slot 0, 1, 2, … and a byte moves on each valid/ready handshake.
- R7: The flash holds 0xE0000 bytes. A readback starting at or beyond that offset transfers nothing. A readback extending past it is shortened to end exactly at the limit.
- R8: For a nonzero operation, `busy` is high from the cycle after the start is accepted until the cycle in which `done` pulses. `done` lasts exactly one cycle and is never high together with `busy`.
- R9: A start pulse arriving while `busy` is high is ignored. It changes neither the running command sequence nor the mode or length of the running operation.
- R10: `cmd_go` is a single-cycle pulse. No new command is launched until the engine has signalled completion of the outstanding one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| rd_mode | input | 1 | 0 = update, 1 = readback; sampled with start |
| xfer_len | input | 24 | Image length or readback length in bytes |
| rd_addr | input | 24 | Readback start offset |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| in_valid | input | 1 | Image byte available |
| in_data | input | 8 | Image byte |
| in_ready | output | 1 | Sequencer takes an image byte |
| tx_we | output | 1 | Write strobe into engine transmit buffer |
| tx_idx | output | 8 | Transmit buffer slot |
| tx_byte | output | 8 | Byte written to transmit buffer |
| out_valid | output | 1 | Readback byte available |
| out_data | output | 8 | Readback byte |
| out_ready | input | 1 | Consumer takes a readback byte |
| rx_idx | output | 8 | Receive buffer slot being presented |
| rx_byte | input | 8 | Receive buffer contents at `rx_idx` |
| cmd_go | output | 1 | One-cycle command launch |
| cmd_op | output | 8 | Command opcode |
| cmd_clocks | output | 16 | Serial clock count for the command |
| cmd_addr | output | 24 | Command flash address |
| eng_done | input | 1 | Engine finished the outstanding command |
| eng_status | input | 8 | Status byte returned with `eng_done` |

## Verification
The assertions assume the engine raises `eng_done` only while a command is outstanding. They also assume `rx_byte` reflects the buffer slot addressed by `rx_idx` within the same cycle. The bench engine model enforces both: it answers each `cmd_go` exactly once after a fixed latency, and it recomputes the receive byte from the last read address and `rx_idx`. Image lengths stay below capacity, so every page address fits in the flash. The bench also withholds `in_valid` and `out_ready` on a fixed cadence, so that stalls inside a page or a chunk exercise the handshakes without breaking these assumptions.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WREN_E,
    ST_ERASE,
    ST_POLL,
    ST_WREN_P,
    ST_FILL,
    ST_PROG,
    ST_READ,
    ST_DRAIN
  } seq_state_e;

  localparam logic [7:0] OP_WREN  = 8'h60;
  localparam logic [7:0] OP_ERASE = 8'hE3;
  localparam logic [7:0] OP_RDSR  = 8'hA0;
  localparam logic [7:0] OP_PROG  = 8'h40;
  localparam logic [7:0] OP_READ  = 8'hC0;

  localparam int unsigned CLK_WREN      = 8;
  localparam int unsigned CLK_ERASE     = 8;
  localparam int unsigned CLK_RDSR      = 16;
  localparam int unsigned CLK_XFER_BASE = 32;
  localparam int unsigned BITS_PER_BYTE = 8;

endpackage

// File: rtl/fseq_cmd_port.sv
module fseq_cmd_port #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned CLK_W    = 16,
  parameter int unsigned BUSY_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [7:0]        op_in,
  input  logic [CLK_W-1:0]  clk_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              eng_done,
  input  logic [7:0]        eng_status,
  output logic              cmd_go,
  output logic [7:0]        cmd_op,
  output logic [CLK_W-1:0]  cmd_clocks,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              pend,
  output logic              fin,
  output logic              stat_busy
);

  localparam logic [7:0] BUSY_MASK = 8'(1 << BUSY_BIT);

  assign fin       = eng_done && pend;
  assign stat_busy = (eng_status & BUSY_MASK) != 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_go     <= 1'b0;
      cmd_op     <= '0;
      cmd_clocks <= '0;
      cmd_addr   <= '0;
      pend       <= 1'b0;
    end else begin
      cmd_go <= launch;
      if (launch) begin
        cmd_op     <= op_in;
        cmd_clocks <= clk_in;
        cmd_addr   <= addr_in;
        pend       <= 1'b1;
      end else if (fin) begin
        pend <= 1'b0;
      end
    end
  end

  // R10
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !pend);

  // R10
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> !cmd_go);

  // R10
  done_has_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> pend);

endmodule

// File: rtl/fseq_xfer.sv
module fseq_xfer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic [W-1:0] idx,
  output logic         last
);

  assign last = active && step && (idx == lim - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx <= '0;
    else if (!active)  idx <= '0;
    else if (step)     idx <= idx + W'(1);
  end

  // R3
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idx < lim));

endmodule

// File: rtl/fseq_span.sv
module fseq_span #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LEN_W  = 24,
  parameter int unsigned CAP    = 917504
) (
  input  logic [ADDR_W-1:0] off,
  input  logic [LEN_W-1:0]  len,
  output logic [LEN_W-1:0]  eff
);

  localparam int unsigned SW = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

  logic [SW-1:0] off_x, len_x, cap_x, room;

  always_comb begin
    off_x = SW'(off);
    len_x = SW'(len);
    cap_x = SW'(CAP);
    room  = '0;
    eff   = '0;
    if (off_x < cap_x) begin
      room = cap_x - off_x;
      eff  = (len_x > room) ? LEN_W'(room) : len;
    end
  end

endmodule

// File: rtl/flash_reprog_seq.sv
module flash_reprog_seq
  import fseq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned LEN_W       = 24,
  parameter int unsigned CLK_W       = 16,
  parameter int unsigned PAGE_BYTES  = 128,
  parameter int unsigned READ_MAX    = 247,
  parameter int unsigned FLASH_BYTES = 917504,
  parameter int unsigned BUSY_BIT    = 7,
  localparam int unsigned CH_MAX = (PAGE_BYTES > READ_MAX) ? PAGE_BYTES : READ_MAX,
  localparam int unsigned CH_W   = $clog2(CH_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_mode,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              done,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              tx_we,
  output logic [CH_W-1:0]   tx_idx,
  output logic [7:0]        tx_byte,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic [CH_W-1:0]   rx_idx,
  input  logic [7:0]        rx_byte,
  output logic              cmd_go,
  output logic [7:0]        cmd_op,
  output logic [CLK_W-1:0]  cmd_clocks,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              eng_done,
  input  logic [7:0]        eng_status
);

  // Arithmetic helpers
  function automatic logic [CH_W-1:0] take_chunk(input logic [LEN_W-1:0] rem,
                                                 input int unsigned lim);
    if (rem > LEN_W'(lim)) return CH_W'(lim);
    return rem[CH_W-1:0];
  endfunction

  function automatic logic [CLK_W-1:0] xfer_clocks(input logic [CH_W-1:0] n);
    return CLK_W'(CLK_XFER_BASE) + CLK_W'(n) * CLK_W'(BITS_PER_BYTE);
  endfunction

  seq_state_e         state;
  logic               issued;
  logic [ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]   remain_q;
  logic [CH_W-1:0]    chunk_q;
  logic               done_q;

  // Named internal events
  logic               cmd_state, launch, fin, pend, stat_busy;
  logic               fill_last, drain_last, finish_evt;
  logic               poll_clear;
  logic [LEN_W-1:0]   eff_len, rem_after;
  logic [7:0]         op_sel;
  logic [CLK_W-1:0]   clk_sel;

  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign in_ready  = (state == ST_FILL);
  assign tx_we     = in_valid && in_ready;
  assign tx_byte   = in_data;
  assign out_valid = (state == ST_DRAIN);
  assign out_data  = rx_byte;

  assign cmd_state = (state == ST_WREN_E) || (state == ST_ERASE) || (state == ST_POLL) ||
                     (state == ST_WREN_P) || (state == ST_PROG)  || (state == ST_READ);
  assign launch    = cmd_state && !issued;
  assign rem_after = remain_q - LEN_W'(chunk_q);
  assign poll_clear = (state == ST_POLL) && fin && !stat_busy;

  assign finish_evt =
      ((state == ST_IDLE) && start && (rd_mode ? (eff_len == '0) : (xfer_len == '0))) ||
      (poll_clear && (remain_q == '0)) ||
      (drain_last && (rem_after == '0));

  always_comb begin
    op_sel  = OP_RDSR;
    clk_sel = CLK_W'(CLK_RDSR);
    case (state)
      ST_WREN_E, ST_WREN_P: begin op_sel = OP_WREN;  clk_sel = CLK_W'(CLK_WREN);  end
      ST_ERASE:             begin op_sel = OP_ERASE; clk_sel = CLK_W'(CLK_ERASE); end
      ST_PROG:              begin op_sel = OP_PROG;  clk_sel = xfer_clocks(chunk_q); end
      ST_READ:              begin op_sel = OP_READ;  clk_sel = xfer_clocks(chunk_q); end
      default:              begin op_sel = OP_RDSR;  clk_sel = CLK_W'(CLK_RDSR);  end
    endcase
  end

  fseq_span #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CAP(FLASH_BYTES)) u_span (
    .off (rd_addr),
    .len (xfer_len),
    .eff (eff_len)
  );

  fseq_cmd_port #(.ADDR_W(ADDR_W), .CLK_W(CLK_W), .BUSY_BIT(BUSY_BIT)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .op_in      (op_sel),
    .clk_in     (clk_sel),
    .addr_in    (addr_q),
    .eng_done   (eng_done),
    .eng_status (eng_status),
    .cmd_go     (cmd_go),
    .cmd_op     (cmd_op),
    .cmd_clocks (cmd_clocks),
    .cmd_addr   (cmd_addr),
    .pend       (pend),
    .fin        (fin),
    .stat_busy  (stat_busy)
  );

  fseq_xfer #(.W(CH_W)) u_fill (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (state == ST_FILL),
    .step   (tx_we),
    .lim    (chunk_q),
    .idx    (tx_idx),
    .last   (fill_last)
  );

  fseq_xfer #(.W(CH_W)) u_drain (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (state == ST_DRAIN),
    .step   (out_valid && out_ready),
    .lim    (chunk_q),
    .idx    (rx_idx),
    .last   (drain_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      issued   <= 1'b0;
      addr_q   <= '0;
      remain_q <= '0;
      chunk_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish_evt;
      if (fin)         issued <= 1'b0;
      else if (launch) issued <= 1'b1;

      case (state)
        ST_IDLE: if (start && !finish_evt) begin
          if (rd_mode) begin
            addr_q   <= rd_addr;
            remain_q <= eff_len;
            chunk_q  <= take_chunk(eff_len, READ_MAX);
            state    <= ST_READ;
          end else begin
            addr_q   <= '0;
            remain_q <= xfer_len;
            state    <= ST_WREN_E;
          end
        end
        ST_WREN_E: if (fin) state <= ST_ERASE;
        ST_ERASE:  if (fin) state <= ST_POLL;
        ST_POLL: if (poll_clear) begin
          state <= (remain_q == '0) ? ST_IDLE : ST_WREN_P;
        end
        ST_WREN_P: if (fin) begin
          chunk_q <= take_chunk(remain_q, PAGE_BYTES);
          state   <= ST_FILL;
        end
        ST_FILL: if (fill_last) state <= ST_PROG;
        ST_PROG: if (fin) begin
          addr_q   <= addr_q + ADDR_W'(chunk_q);
          remain_q <= rem_after;
          state    <= ST_POLL;
        end
        ST_READ: if (fin) state <= ST_DRAIN;
        ST_DRAIN: if (drain_last) begin
          addr_q   <= addr_q + ADDR_W'(chunk_q);
          remain_q <= rem_after;
          if (rem_after == '0) begin
            state <= ST_IDLE;
          end else begin
            chunk_q <= take_chunk(rem_after, READ_MAX);
            state   <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  poll_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POLL && fin && stat_busy) |=> (state == ST_POLL));

  // R3
  page_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && state == ST_PROG) |-> (chunk_q != '0 && chunk_q <= CH_W'(PAGE_BYTES)));

  // R6
  read_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && state == ST_READ) |-> (chunk_q != '0 && chunk_q <= CH_W'(READ_MAX)));

  // R7
  read_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && state == ST_READ) |-> ((32'(addr_q) + 32'(chunk_q)) <= 32'(FLASH_BYTES)));

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !finish_evt) |=> busy);

endmodule

// File: tb/tb_flash_reprog_seq.sv
`timescale 1ns/1ps
module tb_flash_reprog_seq;

  localparam int CAP   = 917504;
  localparam int PAGE  = 128;
  localparam int RMAX  = 247;
  localparam int LOGN  = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, rd_mode = 1'b0;
  logic [23:0] xfer_len = '0, rd_addr = '0;
  logic        busy, done;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, tx_we;
  logic [7:0]  tx_idx, tx_byte;
  logic        out_valid, out_ready = 1'b0;
  logic [7:0]  out_data, rx_idx, rx_byte;
  logic        cmd_go;
  logic [7:0]  cmd_op;
  logic [15:0] cmd_clocks;
  logic [23:0] cmd_addr;
  logic        eng_done = 1'b0;
  logic [7:0]  eng_status = '0;

  always #2.5 clk = ~clk;

  flash_reprog_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode),
    .xfer_len(xfer_len), .rd_addr(rd_addr), .busy(busy), .done(done),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .tx_we(tx_we), .tx_idx(tx_idx), .tx_byte(tx_byte),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .rx_idx(rx_idx), .rx_byte(rx_byte),
    .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_clocks(cmd_clocks), .cmd_addr(cmd_addr),
    .eng_done(eng_done), .eng_status(eng_status)
  );

  function automatic logic [7:0] img(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] pat(input int a);
    return 8'(a & 255) ^ 8'((a >> 8) & 255) ^ 8'h5A;
  endfunction

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // engine model and command log
  logic [7:0]  log_op  [LOGN];
  logic [15:0] log_clk [LOGN];
  logic [23:0] log_adr [LOGN];
  int n_cmd = 0, eng_cnt = 0, polls_seen = 0, busy_polls = 0, overlap = 0;
  logic [7:0]  cur_op = '0;
  logic [23:0] rd_base = '0;

  assign rx_byte = pat(int'(rd_base) + int'(rx_idx));

  initial begin
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (!rst_n) begin
        eng_cnt = 0;
      end else begin
        if (eng_cnt > 0) begin
          eng_cnt--;
          if (eng_cnt == 0) begin
            eng_done = 1'b1;
            if (cur_op == 8'hA0 && polls_seen < busy_polls) eng_status = 8'h83;
            else eng_status = 8'h02;
            if (cur_op == 8'hA0) polls_seen++;
          end
        end
        if (cmd_go) begin
          if (eng_cnt > 0 || eng_done) overlap++;
          if (n_cmd < LOGN) begin
            log_op[n_cmd] = cmd_op; log_clk[n_cmd] = cmd_clocks; log_adr[n_cmd] = cmd_addr;
          end
          n_cmd++;
          cur_op = cmd_op;
          if (cmd_op != 8'hA0) polls_seen = 0;
          if (cmd_op == 8'hC0) rd_base = cmd_addr;
          eng_cnt = 2;
        end
      end
    end
  end

  // image byte source with gaps
  int in_pos = 0, tx_bad = 0, src_ctr = 0;
  bit took_in = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (took_in) in_pos++;
      src_ctr++;
      in_valid = (src_ctr % 4) != 1;
      in_data  = img(in_pos);
      #1;
      took_in = in_valid && in_ready;
      if (took_in && !(tx_we && int'(tx_idx) == in_pos % PAGE && tx_byte == img(in_pos)))
        tx_bad++;
    end
  end

  // readback sink with stalls
  int out_cnt = 0, out_bad = 0, snk_ctr = 0, exp_off = 0;
  initial begin
    forever begin
      @(negedge clk);
      snk_ctr++;
      out_ready = (snk_ctr % 5) != 2;
      #1;
      if (out_valid && out_ready) begin
        if (out_data != pat(exp_off + out_cnt)) out_bad++;
        out_cnt++;
      end
    end
  end

  // expected command list
  logic [7:0]  e_op  [LOGN];
  logic [15:0] e_clk [LOGN];
  logic [23:0] e_adr [LOGN];
  int n_exp;

  task automatic push(input logic [7:0] op, input int clks, input int adr);
    if (n_exp < LOGN) begin
      e_op[n_exp] = op; e_clk[n_exp] = 16'(clks); e_adr[n_exp] = 24'(adr);
    end
    n_exp++;
  endtask

  function automatic int eff_of(input int off, input int len);
    if (off >= CAP) return 0;
    return (len < CAP - off) ? len : CAP - off;
  endfunction

  task automatic build_exp(input int mode, input int len, input int off, input int polls);
    n_exp = 0;
    if (mode == 0) begin
      if (len > 0) begin
        push(8'h60, 8, 0); push(8'hE3, 8, 0);
        for (int p = 0; p <= polls; p++) push(8'hA0, 16, 0);
        for (int a = 0; a < len; a += PAGE) begin
          automatic int n = (len - a < PAGE) ? len - a : PAGE;
          push(8'h60, 8, 0);
          push(8'h40, 32 + 8 * n, a);
          for (int p = 0; p <= polls; p++) push(8'hA0, 16, 0);
        end
      end
    end else begin
      automatic int eff = eff_of(off, len);
      for (int a = 0; a < eff; a += RMAX) begin
        automatic int n = (eff - a < RMAX) ? eff - a : RMAX;
        push(8'hC0, 32 + 8 * n, off + a);
      end
    end
  endtask

  task automatic run_op(input int mode, input int len, input int off,
                        input int polls, input bit inj);
    int cyc, bad, exp_bytes;
    string tag;
    tag = (mode == 0) ? "R2/R3/R4" : "R6/R7";
    busy_polls = polls; n_cmd = 0; overlap = 0;
    in_pos = 0; tx_bad = 0; out_cnt = 0; out_bad = 0; exp_off = off;
    @(negedge clk);
    rd_mode = mode[0]; xfer_len = 24'(len); rd_addr = 24'(off); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp_bytes = (mode == 0) ? len : eff_of(off, len);
    if (exp_bytes == 0) begin
      // R5
      chk(done && !busy, "R5", "done in cycle after zero-length start", done, 1);
    end else begin
      // R8
      chk(busy && !done, "R8", "busy after start", busy, 1);
    end
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (inj && cyc == 40) begin
        // R9: start while busy, with a different mode and length
        rd_mode = ~rd_mode; xfer_len = 24'd3; start = 1'b1;
      end else start = 1'b0;
    end
    chk(done, "R8", "operation completes", cyc, 0);
    chk(!busy, "R8", "busy low with done", busy, 0);
    @(negedge clk);
    chk(!done, "R8", "done lasts one cycle", done, 0);
    repeat (8) @(negedge clk);
    build_exp(mode, len, off, polls);
    chk(n_cmd == n_exp, tag, "command count", n_cmd, n_exp);
    bad = 0;
    for (int k = 0; k < n_exp && k < n_cmd && k < LOGN; k++) begin
      if (log_op[k] != e_op[k] || log_clk[k] != e_clk[k]) bad++;
      else if ((e_op[k] == 8'h40 || e_op[k] == 8'hC0) && log_adr[k] != e_adr[k]) bad++;
    end
    chk(bad == 0, tag, "command op/clocks/addr mismatches", bad, 0);
    chk(overlap == 0, "R10", "command launched while outstanding", overlap, 0);
    if (mode == 0) begin
      chk(in_pos == len && tx_bad == 0, "R3", "image bytes taken / bad", tx_bad, 0);
    end else begin
      chk(out_cnt == exp_bytes, "R6", "readback byte count", out_cnt, exp_bytes);
      chk(out_bad == 0, "R6", "readback byte mismatches", out_bad, 0);
    end
  endtask

  localparam int NV = 8;
  localparam int V_MODE [NV] = '{0, 0, 0, 0, 1, 1, 1, 1};
  localparam int V_LEN  [NV] = '{1, 128, 300, 129, 10, 500, 100, 247};
  localparam int V_OFF  [NV] = '{0, 0, 0, 0, 0, 16, 917488, 256};
  localparam int V_POLL [NV] = '{1, 0, 2, 1, 0, 0, 0, 0};

  initial begin
    #(5.0 * 190000);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !cmd_go && !in_ready && !out_valid, "R1",
        "outputs during reset", {busy, done, cmd_go, in_ready, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !cmd_go && !in_ready && !out_valid, "R1",
        "outputs after reset release", {busy, done, cmd_go, in_ready, out_valid}, 0);

    for (int v = 0; v < NV; v++) run_op(V_MODE[v], V_LEN[v], V_OFF[v], V_POLL[v], 1'b0);

    // R5: zero-length update and empty readback
    run_op(0, 0, 0, 0, 1'b0);
    // R7: start at the limit and beyond
    run_op(1, 5, CAP, 0, 1'b0);
    run_op(1, 9, CAP + 5, 0, 1'b0);
    // R4: two full pages plus a short tail, with busy polls
    run_op(0, 260, 0, 3, 1'b0);
    // R9: a start during a running update is ignored
    run_op(0, 300, 0, 1, 1'b1);

    // R1: reset in the middle of an update
    n_cmd = 0;
    @(negedge clk);
    rd_mode = 1'b0; xfer_len = 24'd200; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !cmd_go && !in_ready && !out_valid, "R1",
        "outputs in mid-run reset", {busy, done, cmd_go, in_ready, out_valid}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_cmd = 0;
    repeat (10) @(negedge clk);
    chk(n_cmd == 0 && !busy, "R1", "no commands after reset", n_cmd, 0);
    run_op(1, 20, 100, 0, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule